// File: doc/BRIEF.md
# Double-Buffered Display Configuration Register File

This block holds the configuration words of a display engine in two copies. Software writes land only in a shadow copy. A second, active copy drives the pixel datapath. The shadow contents move into the active copy as one unit, in the single clock cycle of a vertical-blanking-start pulse. Because of this, a frame never runs with a half-updated configuration.

Software reaches the block through a simple single-cycle register bus. Writes are synchronous. Reads are combinational and return shadow contents, so software sees its own writes immediately.

A control word at address 0 selects between two loading modes:
- **Automatic:** every vblank copies the shadows into the active copy.
- **Explicit:** software sets a load-request bit. That bit stays set until the next vblank performs the copy, then clears itself. Software polls the bit to learn when the next update may begin.

Top module: `shadow_reg_bank`

## Requirements
- R1: After reset, every shadow and active word is zero and the control word reads zero, which means automatic loading is selected and no load is pending.
- R2: A write to configuration address k (1 to NUM_REGS) stores the data in shadow word k, and a read of address k returns it from the next cycle. Active word k (bits (k-1)*DATA_W upward of `cfg_active`) is not changed by the write.
- R3: The control word is at address 0. Bit 1 is the automatic-load-off flag and is read and written directly. Bit 0 reads back the pending-load flag. All other bits read zero.
- R4: With bit 1 set and no load pending, a vblank pulse leaves every active word unchanged.
- R5: Writing the control word with bit 0 set makes the pending flag read 1. At the next vblank pulse, every active word takes its shadow value in that same cycle, and the pending flag reads 0 afterwards.
- R6: With bit 1 clear, every vblank pulse copies all shadow words to the active words, whatever the pending flag holds.
- R7: A load request written in the cycle of a vblank pulse is not served by that pulse. The pending flag stays 1 and the copy happens at the following pulse.
- R8: A configuration write in the cycle of a copy goes to the shadow only. The active word receives the shadow value from before that write.
- R9: Writing the control word with bit 0 clear does not cancel a pending load.
- R10: Every configuration word accepts a full-word write of zero, and a commit then clears its active word.
- R11: Writes to addresses above NUM_REGS change no shadow word, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Word address for both reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| cfg_active | output | NUM_REGS*DATA_W | Active configuration words, word 1 in the low bits |

## Verification
A bus write and the vblank pulse can arrive in the same cycle. The bench provokes this in two ways:
- It writes a load request together with the pulse. The pulse must leave the active words alone and keep the request pending for the next pulse.
- It writes a configuration word together with a pulse that performs a copy. The active word must take the value from before the write, while the shadow must take the new value.

The bench judges both cases by reading the control and shadow words back over the bus and by comparing `cfg_active` slices one cycle after the pulse.

// File: rtl/shadow_reg_bank_pkg.sv
// Package: shared constants for the double-buffered register file.
// Assumes the control word sits at address 0 and the configuration words follow it.
package shadow_reg_bank_pkg;

    localparam int CTRL_ADDR      = 0;
    localparam int CTRL_LOAD_BIT  = 0;
    localparam int CTRL_NOAUTO_BIT = 1;

    typedef struct packed {
        logic load_pend;
        logic autoload_off;
    } ctrl_state_t;

endpackage

// File: rtl/sbk_commit_ctrl.sv
// Commit controller: holds the load-mode flag and the self-clearing
// load-request flag, and decides when the bank copies shadow to active.
// Assumes vblank_start is a single-cycle pulse synchronous to clk.
module sbk_commit_ctrl
    import shadow_reg_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_bits,
    input  logic       vblank_start,
    output logic       copy_en,
    output ctrl_state_t state_q
);

    ctrl_state_t state_d;

    // Copy when a load was pending before this cycle, or automatic mode is on.
    always_comb begin
        copy_en = vblank_start && (state_q.load_pend || !state_q.autoload_off);
    end

    // Next state: a pulse retires the old request; a new request always sticks.
    always_comb begin
        state_d = state_q;
        if (vblank_start) begin
            state_d.load_pend = 1'b0;
        end
        if (ctrl_wr) begin
            state_d.autoload_off = ctrl_bits[CTRL_NOAUTO_BIT];
            if (ctrl_bits[CTRL_LOAD_BIT]) begin
                state_d.load_pend = 1'b1;
            end
        end
    end

    // Control state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sbk_reg_slot.sv
// One configuration word: a shadow register written by the bus and an
// active register loaded from the shadow when copy_en is high.
// Assumes the caller decodes the address into wr_sel.
module sbk_reg_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              copy_en,
    output logic [DATA_W-1:0] shadow_q,
    output logic [DATA_W-1:0] active_q
);

    // Shadow copy: takes bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_sel) begin
            shadow_q <= wdata;
        end
    end

    // Active copy: takes the shadow value from before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (copy_en) begin
            active_q <= shadow_q;
        end
    end

endmodule

// File: rtl/sbk_read_mux.sv
// Read path: returns the control word at address 0, shadow words at
// 1..NUM_REGS, and zero everywhere else.
// Assumes the address is stable during the read cycle.
module sbk_read_mux
    import shadow_reg_bank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_REGS*DATA_W-1:0] shadow_flat,
    input  ctrl_state_t                ctrl_state,
    output logic [DATA_W-1:0]          rdata
);

    // Address decode of the read data.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rdata[CTRL_LOAD_BIT]   = ctrl_state.load_pend;
            rdata[CTRL_NOAUTO_BIT] = ctrl_state.autoload_off;
        end
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i + 1)) begin
                rdata = shadow_flat[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/shadow_reg_bank.sv
// Top: double-buffered configuration register file for a display engine.
// The bus writes shadow words; all active words load atomically on a
// vblank pulse, either every frame or only after an explicit request.
// Assumes a single-cycle bus with no wait states.
module shadow_reg_bank
    import shadow_reg_bank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic                       vblank_start,
    output logic [NUM_REGS*DATA_W-1:0] cfg_active
);

    localparam int BANK_W = NUM_REGS * DATA_W;

    logic              ctrl_wr;
    logic              copy_en;
    ctrl_state_t       ctrl_state;
    logic [BANK_W-1:0] shadow_flat;

    // Control-word write strobe.
    always_comb begin
        ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    end

    sbk_commit_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_bits    (wdata[1:0]),
        .vblank_start (vblank_start),
        .copy_en      (copy_en),
        .state_q      (ctrl_state)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        logic wr_sel;

        // Per-word write decode.
        always_comb begin
            wr_sel = wr_en && (addr == ADDR_W'(g + 1));
        end

        sbk_reg_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_sel),
            .wdata    (wdata),
            .copy_en  (copy_en),
            .shadow_q (shadow_flat[g*DATA_W +: DATA_W]),
            .active_q (cfg_active[g*DATA_W +: DATA_W])
        );
    end

    sbk_read_mux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rd (
        .addr        (addr),
        .shadow_flat (shadow_flat),
        .ctrl_state  (ctrl_state),
        .rdata       (rdata)
    );

endmodule

// File: rtl/shadow_reg_bank_chk.sv
// Checker: temporal properties of the commit and copy behaviour,
// bound into every shadow_reg_bank instance.
module shadow_reg_bank_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          addr,
    input logic                       wdata_load,
    input logic                       vblank_start,
    input logic [NUM_REGS*DATA_W-1:0] cfg_active,
    input logic [NUM_REGS*DATA_W-1:0] shadow_flat,
    input logic                       load_pend,
    input logic                       autoload_off
);

    logic load_wr;
    assign load_wr = wr_en && (addr == '0) && wdata_load;

    // R2
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank_start |=> $stable(cfg_active));

    // R4
    idle_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && autoload_off && !load_pend) |=> $stable(cfg_active));

    // R5
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && load_pend) |=> (cfg_active == $past(shadow_flat)));

    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && !load_wr) |=> !load_pend);

    // R6
    auto_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && !autoload_off) |=> (cfg_active == $past(shadow_flat)));

    // R7
    late_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && load_wr) |=> load_pend);

    // R9
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pend && !vblank_start) |=> load_pend);

    // R11
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADDR_W'(NUM_REGS)) |=> $stable(shadow_flat));

endmodule

bind shadow_reg_bank shadow_reg_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata_load   (wdata[0]),
    .vblank_start (vblank_start),
    .cfg_active   (cfg_active),
    .shadow_flat  (shadow_flat),
    .load_pend    (ctrl_state.load_pend),
    .autoload_off (ctrl_state.autoload_off)
);

// File: tb/shadow_reg_bank_test.sv
// Directed bench for shadow_reg_bank; one task per scenario.
module shadow_reg_bank_test;

    localparam int NUM_REGS = 8;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = $clog2(NUM_REGS + 1);

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       wr_en = 1'b0;
    logic [ADDR_W-1:0]          addr = '0;
    logic [DATA_W-1:0]          wdata = '0;
    logic [DATA_W-1:0]          rdata;
    logic                       vblank_start = 1'b0;
    logic [NUM_REGS*DATA_W-1:0] cfg_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    shadow_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .vblank_start (vblank_start),
        .cfg_active   (cfg_active)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] active_word(input int k);
        return cfg_active[(k-1)*DATA_W +: DATA_W];
    endfunction

    // One bus cycle, optionally together with a vblank pulse.
    task automatic cycle(input bit we, input int a, input logic [DATA_W-1:0] d,
                         input bit vb);
        @(negedge clk);
        wr_en = we; addr = ADDR_W'(a); wdata = d; vblank_start = vb;
        @(negedge clk);
        wr_en = 1'b0; vblank_start = 1'b0;
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        cycle(1'b1, a, d, 1'b0);
    endtask

    task automatic vblank();
        cycle(1'b0, 0, '0, 1'b1);
    endtask

    task automatic rd(input int a, output logic [DATA_W-1:0] d);
        addr = ADDR_W'(a);
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        rd(0, v);
        check("R1 ctrl", v, '0);
        for (int k = 1; k <= NUM_REGS; k++) begin
            rd(k, v);
            check("R1 shadow", v, '0);
            check("R1 active", active_word(k), '0);
        end
    endtask

    task automatic t_autoload();
        logic [DATA_W-1:0] v;
        wr(1, 32'hA5A5_0001);
        rd(1, v);
        check("R2 shadow readback", v, 32'hA5A5_0001);
        check("R2 active untouched", active_word(1), '0);
        vblank();
        check("R6 auto copy", active_word(1), 32'hA5A5_0001);
    endtask

    task automatic t_explicit();
        logic [DATA_W-1:0] v;
        wr(0, 32'h2);
        rd(0, v);
        check("R3 ctrl mode bit", v, 32'h2);
        wr(2, 32'hBEEF_0002);
        vblank();
        check("R4 no copy", active_word(2), '0);
        wr(0, 32'h3);
        rd(0, v);
        check("R5 pending reads 1", v, 32'h3);
        wr(0, 32'h2);
        rd(0, v);
        check("R9 pending kept", v, 32'h3);
        check("R5 no copy before vblank", active_word(2), '0);
        vblank();
        check("R5 copy on vblank", active_word(2), 32'hBEEF_0002);
        rd(0, v);
        check("R5 pending cleared", v, 32'h2);
    endtask

    task automatic t_commit_on_vblank();
        logic [DATA_W-1:0] v;
        wr(3, 32'hC0DE_0003);
        cycle(1'b1, 0, 32'h3, 1'b1);
        check("R7 no copy same cycle", active_word(3), '0);
        rd(0, v);
        check("R7 still pending", v, 32'h3);
        vblank();
        check("R7 copy next vblank", active_word(3), 32'hC0DE_0003);
        rd(0, v);
        check("R7 cleared after", v, 32'h2);
    endtask

    task automatic t_write_on_copy();
        logic [DATA_W-1:0] v;
        wr(4, 32'hD000_0001);
        wr(0, 32'h3);
        cycle(1'b1, 4, 32'hD000_0002, 1'b1);
        check("R8 active old value", active_word(4), 32'hD000_0001);
        rd(4, v);
        check("R8 shadow new value", v, 32'hD000_0002);
        wr(0, 32'h3);
        vblank();
        check("R8 later copy", active_word(4), 32'hD000_0002);
    endtask

    task automatic t_clear();
        logic [DATA_W-1:0] v;
        for (int k = 1; k <= NUM_REGS; k++) wr(k, 32'hF0 + DATA_W'(k));
        wr(0, 32'h3);
        vblank();
        check("R10 filled", active_word(NUM_REGS), 32'hF0 + DATA_W'(NUM_REGS));
        for (int k = 1; k <= NUM_REGS; k++) wr(k, '0);
        wr(0, 32'h3);
        vblank();
        for (int k = 1; k <= NUM_REGS; k++) begin
            rd(k, v);
            check("R10 shadow zero", v, '0);
            check("R10 active zero", active_word(k), '0);
        end
    endtask

    task automatic t_out_of_range();
        logic [DATA_W-1:0] v;
        wr(NUM_REGS + 1, 32'h1234_5678);
        wr((1 << ADDR_W) - 1, 32'h8765_4321);
        rd(NUM_REGS + 1, v);
        check("R11 read zero", v, '0);
        rd((1 << ADDR_W) - 1, v);
        check("R11 read zero top", v, '0);
        for (int k = 1; k <= NUM_REGS; k++) begin
            rd(k, v);
            check("R11 shadow unchanged", v, '0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_autoload();
        t_explicit();
        t_commit_on_vblank();
        t_write_on_copy();
        t_clear();
        t_out_of_range();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule